// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind a serial memory front end and turns a write transaction into one self-timed array programming cycle. A transaction opens with a start address. The front end then delivers whole data bytes one at a time, and each byte lands in a page-sized staging buffer. When chip select returns high, the front end reports that event together with a flag that tells whether the last bit shifted in completed a byte. Only a rise that falls exactly on a byte boundary commits the buffer. Any other rise throws the transaction away.

During the commit the controller holds a busy flag for a fixed, parameterised number of clocks. It sweeps the staging buffer and issues array write strobes only for the locations that received a byte. When the cycle ends it pulses a clear request to the external write-enable latch. A single-byte write is handled as a page write that carries one byte. A simple synchronous RAM model of the array is included, and it has a read port so the stored contents can be observed.

The state machine has four states. ST_IDLE moves to ST_LOAD on an accepted start (start strobe while the write-enable latch is set). ST_LOAD moves to ST_PROGRAM on a qualified commit (chip-select rise on a byte boundary with at least one byte staged). ST_LOAD moves back to ST_IDLE on a discard (any other chip-select rise). ST_PROGRAM moves to ST_FINISH when the timer expires. ST_FINISH returns to ST_IDLE after one cycle.

Top module: `pwc_page_writer`

## Requirements
- R1: After reset, busy, wel_clear and arr_we are all 0.
- R2: A start strobe is accepted only while the block is idle and wel_state is 1. A start seen with wel_state 0 is ignored, so later bytes and chip-select rises produce no busy. The first byte after an accepted start goes to start_addr, and each further byte goes to the next higher address.
- R3: The address advances only in its low 6 bits (PAGE_BYTES = 64). A byte received after the last location of the page goes to location 0 of the same page and overwrites whatever was staged there.
- R4: A commit happens only on cs_rise with cs_on_boundary = 1 and at least one byte staged. A rise with cs_on_boundary = 0, or a rise with no staged byte, discards the transaction: busy stays 0 and the array is unchanged.
- R5: After a qualified commit, busy is 1 for exactly CYCLE_CLKS clock cycles. It rises in the cycle after the edge that samples cs_rise.
- R6: During the write cycle, only the page locations that received a byte in the transaction are written: one arr_we pulse per distinct location. All other locations keep their contents.
- R7: wel_clear is a single-cycle pulse. It is high in the one cycle right after busy falls, and at no other time.
- R8: While busy is 1, start, byte and chip-select inputs are ignored. No later cycle starts from them, and no staged or array data changes.
- R9: A transaction carrying a single byte commits and writes exactly that one location.
- R10: arr_we is 1 only while busy is 1, and every address written within one cycle lies in the same page.
- R11: rd_data returns the array byte at rd_addr one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start of a write transaction; start_addr is valid |
| start_addr | input | ADDR_W | First byte address of the transaction |
| wel_state | input | 1 | Current state of the write-enable latch |
| byte_valid | input | 1 | One complete data byte is present on byte_data |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip select has just gone high |
| cs_on_boundary | input | 1 | The rise came right after the last bit of a byte |
| rd_addr | input | ADDR_W | Array read address |
| busy | output | 1 | Write cycle in progress |
| wel_clear | output | 1 | One-cycle request to clear the write-enable latch |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Array read data, one cycle after rd_addr |

## Verification
A state machine stuck in or skipping ST_PROGRAM shows up at once as a busy run whose length differs from CYCLE_CLKS, or as a missing wel_clear pulse in the cycle after busy falls. A corrupted staging mask or offset counter shows up as a wrong count of arr_we pulses within the same cycle. It also appears as wrong bytes once the page is read back through rd_data, a few cycles later. A write-enable guard that leaks stimulus into a busy or idle block shows up as an unexpected busy rise one cycle after the stray chip-select rise.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_FINISH  = 2'd3
    } pwc_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/pwc_page_buffer.sv
module pwc_page_buffer #(
    parameter int unsigned PAGE_BYTES = 64,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mark,
    output logic              any_mark
);

    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == PAGE_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mark_q[g] <= 1'b0;
            end else if (clr) begin
                mark_q[g] <= 1'b0;
            end else if (hit) begin
                mark_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit && !clr) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_mark  = mark_q[rd_idx];
    assign any_mark = |mark_q;

endmodule

// File: rtl/pwc_addr_track.sv
module pwc_addr_track #(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_BYTES = 64,
    localparam int unsigned PAGE_W    = $clog2(PAGE_BYTES),
    localparam int unsigned BASE_W    = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [BASE_W-1:0] page_base,
    output logic [PAGE_W-1:0] page_off
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_base <= '0;
            page_off  <= '0;
        end else if (load) begin
            page_base <= load_addr[ADDR_W-1:PAGE_W];
            page_off  <= load_addr[PAGE_W-1:0];
        end else if (step) begin
            page_off  <= page_off + 1'b1;
        end
    end

endmodule

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer #(
    parameter int unsigned CYCLE_CLKS = 200,
    localparam int unsigned CNT_W     = $clog2(CYCLE_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == CNT_W'(CYCLE_CLKS - 1));

endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DEPTH = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
        rdata <= cell_q[raddr];
    end

endmodule

// File: rtl/pwc_page_writer.sv
module pwc_page_writer
    import pwc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_BYTES = 64,
    parameter int unsigned CYCLE_CLKS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wel_state,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_on_boundary,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              wel_clear,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic [7:0]        rd_data
);

    localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
    localparam int unsigned BASE_W = ADDR_W - PAGE_W;
    localparam int unsigned CNT_W  = $clog2(CYCLE_CLKS);

    pwc_state_e state_q, state_d;

    logic              accept_start;
    logic              take_byte;
    logic              commit;
    logic              discard;
    logic [BASE_W-1:0] page_base;
    logic [PAGE_W-1:0] page_off;
    logic [CNT_W-1:0]  tmr_count;
    logic              tmr_last;
    logic              sweep_live;
    logic [PAGE_W-1:0] sweep_idx;
    logic [PAGE_W-1:0] buf_rd_idx;
    logic [7:0]        buf_rd_data;
    logic              buf_rd_mark;
    logic              buf_any;

    // transition conditions
    assign accept_start = (state_q == ST_IDLE) && start_valid && wel_state;
    assign take_byte    = (state_q == ST_LOAD) && byte_valid;
    assign commit       = (state_q == ST_LOAD) && cs_rise && cs_on_boundary
                          && (buf_any || byte_valid);
    assign discard      = (state_q == ST_LOAD) && cs_rise && !commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_start) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (commit)       state_d = ST_PROGRAM;
                else if (discard) state_d = ST_IDLE;
            end
            ST_PROGRAM: begin
                if (tmr_last) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        wel_clear  = 1'b0;
        sweep_live = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_LOAD:    ;
            ST_PROGRAM: begin
                busy       = 1'b1;
                sweep_live = (tmr_count < CNT_W'(PAGE_BYTES));
            end
            ST_FINISH: begin
                wel_clear  = 1'b1;
            end
        endcase
    end

    assign sweep_idx  = tmr_count[PAGE_W-1:0];
    assign buf_rd_idx = sweep_idx;
    assign arr_we     = sweep_live && buf_rd_mark;
    assign arr_addr   = {page_base, sweep_idx};
    assign arr_wdata  = buf_rd_data;

    pwc_addr_track #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept_start),
        .load_addr (start_addr),
        .step      (take_byte),
        .page_base (page_base),
        .page_off  (page_off)
    );

    pwc_page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (8)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept_start),
        .wr_en    (take_byte),
        .wr_idx   (page_off),
        .wr_data  (byte_data),
        .rd_idx   (buf_rd_idx),
        .rd_data  (buf_rd_data),
        .rd_mark  (buf_rd_mark),
        .any_mark (buf_any)
    );

    pwc_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (commit),
        .run     (busy),
        .count   (tmr_count),
        .last    (tmr_last)
    );

    pwc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_mem (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/pwc_page_writer_chk.sv
module pwc_page_writer_chk #(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_BYTES = 64,
    parameter int unsigned CYCLE_CLKS = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              cs_on_boundary,
    input logic              busy,
    input logic              wel_clear,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R10
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R10
    same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we) && $past(busy))
        |-> arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W]));

    // R7
    clear_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clear |-> ($past(busy) && !busy));

    // R7
    fall_gives_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> wel_clear);

    // R4
    rise_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_on_boundary));

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == CYCLE_CLKS);

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < CYCLE_CLKS);

endmodule

bind pwc_page_writer pwc_page_writer_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_rise        (cs_rise),
    .cs_on_boundary (cs_on_boundary),
    .busy           (busy),
    .wel_clear      (wel_clear),
    .arr_we         (arr_we),
    .arr_addr       (arr_addr)
);

// File: tb/sim_pwc_page_writer.sv
module sim_pwc_page_writer;

    localparam int  PERIOD = 10;
    localparam int  AW     = 10;
    localparam int  PB     = 64;
    localparam int  CYC    = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          wel_state = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          cs_on_boundary = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy, wel_clear, arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata, rd_data;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_mem [2**AW];

    always #(PERIOD/2) clk = ~clk;

    pwc_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .wel_state(wel_state), .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary), .rd_addr(rd_addr),
        .busy(busy), .wel_clear(wel_clear), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 7 + 1) & 8'hFF);
    endfunction

    // drive one transaction; updates the model if a commit is expected
    task automatic txn(input int addr, input int n, input int seed,
                       input bit bnd, input bit wel);
        @(negedge clk);
        wel_state   = wel;
        start_valid = 1'b1;
        start_addr  = AW'(addr);
        @(negedge clk);
        start_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data  = pat(seed, i);
            @(negedge clk);
        end
        byte_valid     = 1'b0;
        cs_rise        = 1'b1;
        cs_on_boundary = bnd;
        @(negedge clk);
        cs_rise        = 1'b0;
        cs_on_boundary = 1'b0;
        if (wel && bnd && n > 0) begin
            for (int i = 0; i < n; i++) begin
                int a;
                a = (addr & ~(PB-1)) | ((addr + i) & (PB-1));
                exp_mem[a] = pat(seed, i);
            end
        end
    endtask

    // called right after txn when a commit is expected
    task automatic run_cycle(input int exp_writes, input string req);
        int bc = 0;
        int wc = 0;
        chk(busy === 1'b1, "R5 busy rises after commit", int'(busy), 1);
        while (busy === 1'b1 && bc < CYC + 10) begin
            bc++;
            if (arr_we) wc++;
            @(negedge clk);
        end
        chk(bc == CYC, "R5 busy length", bc, CYC);
        chk(wc == exp_writes, req, wc, exp_writes);
        chk(wel_clear === 1'b1, "R7 wel_clear after busy", int'(wel_clear), 1);
        @(negedge clk);
        chk(wel_clear === 1'b0, "R7 wel_clear one cycle", int'(wel_clear), 0);
    endtask

    task automatic no_cycle(input string req);
        int seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (busy || arr_we || wel_clear) seen++;
            @(negedge clk);
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic check_page(input int page, input string req);
        int errs = 0;
        int first_a = -1;
        int first_v = 0;
        for (int i = 0; i < PB; i++) begin
            int a;
            a = page * PB + i;
            rd_addr = AW'(a);
            @(negedge clk);
            if (rd_data !== exp_mem[a]) begin
                if (first_a < 0) begin
                    first_a = a;
                    first_v = int'(rd_data);
                end
                errs++;
            end
        end
        chk(errs == 0, req, first_v, (first_a < 0) ? 0 : int'(exp_mem[first_a]));
    endtask

    task automatic t_reset();
        chk(busy === 1'b0, "R1 busy at reset", int'(busy), 0);
        chk(wel_clear === 1'b0, "R1 wel_clear at reset", int'(wel_clear), 0);
        chk(arr_we === 1'b0, "R1 arr_we at reset", int'(arr_we), 0);
    endtask

    task automatic t_full_pages();
        txn(2 * PB, PB, 1, 1'b1, 1'b1);
        run_cycle(PB, "R6 full page write count");
        check_page(2, "R2 R11 full page 2 contents");
        txn(3 * PB, PB, 2, 1'b1, 1'b1);
        run_cycle(PB, "R6 full page write count");
        check_page(3, "R2 full page 3 contents");
    endtask

    task automatic t_partial();
        txn(2 * PB + 10, 3, 5, 1'b1, 1'b1);
        run_cycle(3, "R6 partial write count");
        check_page(2, "R6 untouched bytes kept");
    endtask

    task automatic t_wrap();
        txn(3 * PB + 60, 70, 9, 1'b1, 1'b1);
        run_cycle(PB, "R3 wrap distinct writes");
        check_page(3, "R3 wrap overwrite");
    endtask

    task automatic t_single();
        txn(3 * PB + 5, 1, 11, 1'b1, 1'b1);
        run_cycle(1, "R9 single byte write count");
        check_page(3, "R9 single byte contents");
    endtask

    task automatic t_discard();
        txn(2 * PB + 20, 4, 13, 1'b0, 1'b1);
        no_cycle("R4 off-boundary rise starts nothing");
        txn(2 * PB + 20, 0, 13, 1'b1, 1'b1);
        no_cycle("R4 empty buffer starts nothing");
        check_page(2, "R4 array unchanged after discard");
    endtask

    task automatic t_no_wel();
        txn(2 * PB + 30, 4, 17, 1'b1, 1'b0);
        no_cycle("R2 start ignored without write enable");
        check_page(2, "R2 array unchanged without write enable");
    endtask

    task automatic t_busy_ignore();
        int bc = 2;
        int wc = 0;
        txn(3 * PB + 40, 2, 19, 1'b1, 1'b1);
        chk(busy === 1'b1, "R8 busy entered", int'(busy), 1);
        // stray traffic while busy, aimed at page 2
        start_valid = 1'b1;
        start_addr  = AW'(2 * PB);
        if (arr_we) wc++;
        @(negedge clk);
        start_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1;
            byte_data  = 8'hA5;
            if (arr_we) wc++;
            @(negedge clk);
            bc++;
        end
        byte_valid     = 1'b0;
        cs_rise        = 1'b1;
        cs_on_boundary = 1'b1;
        if (arr_we) wc++;
        @(negedge clk);
        cs_rise        = 1'b0;
        cs_on_boundary = 1'b0;
        while (busy === 1'b1 && bc < CYC + 10) begin
            bc++;
            if (arr_we) wc++;
            @(negedge clk);
        end
        chk(bc == CYC, "R8 cycle length unaffected", bc, CYC);
        chk(wc == 2, "R8 only committed bytes written", wc, 2);
        @(negedge clk);
        no_cycle("R8 no second cycle from busy-time traffic");
        check_page(2, "R8 page 2 untouched");
        check_page(3, "R8 page 3 holds committed bytes");
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_pages();
        t_partial();
        t_wrap();
        t_single();
        t_discard();
        t_no_wel();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule